// File: doc/BRIEF.md
# Boxcar Smoothing Filter Unit

This block turns a stored column-sum vector into a smoothed stream. On a start request it walks a zero-extended copy of the vector, reads each real sample from the read port of a dual-port memory and emits one averaged sample per clock. The window is a plain moving sum with unit weights. The sum is scaled down by a right shift instead of a divider.

The vector has 136 samples of 15 bits. The window is 19 wide, which is the vector length divided by seven and rounded down. Nine zero positions sit before and after the data, and 153 outputs result. As the window enters the data, the sum holds only the samples that have arrived. In the middle it holds the 19 latest samples. As it leaves the data, the missing positions count as zero. Each sum is shifted right by 4, because 16 is the largest power of two under 19. The start request is the flag raised when the column sums are ready. While a pass runs, a busy flag stays high.

Top module: `boxcar_smoother`

## Requirements
- R1: After reset, busy_o, valid_o, done_o and rd_en_o are all low.
- R2: A start_i sampled high while busy_o is low begins a pass. The first smoothed sample is presented with valid_o on the second rising edge after the edge that sampled start_i.
- R3: A pass presents exactly 153 samples, on consecutive cycles, with valid_o high and in output order k = 0..152.
- R4: Output k is the sum of padded positions max(0,k-18)..k, shifted right by 4. Padded position p holds vector sample p-9 for 9 <= p <= 144 and zero otherwise.
- R5: When the shifted sum exceeds 32767, smooth_o presents 32767.
- R6: In each pass rd_en_o is high on exactly 136 cycles, with rd_addr_o stepping 0,1,..,135. No read is issued for a padding position. Read data is taken from rd_data_i one cycle after its address.
- R7: busy_o is high from the cycle after start_i is accepted up to and including the cycle of the last valid sample. It is low on the following cycle.
- R8: done_o is high for exactly one cycle, the cycle after the last valid sample. valid_o is low in that cycle.
- R9: A start_i that arrives while busy_o is high is ignored. The running pass is not disturbed and no second pass follows.
- R10: Each pass starts from a cleared window. Its results depend only on the vector contents during that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column sums ready; begins a pass when idle |
| rd_en_o | output | 1 | Read enable to memory read port |
| rd_addr_o | output | 8 | Read address, vector sample index |
| rd_data_i | input | 15 | Read data, valid one cycle after address |
| busy_o | output | 1 | Pass in progress |
| valid_o | output | 1 | smooth_o carries a sample |
| smooth_o | output | 15 | Smoothed, shifted and saturated sample |
| done_o | output | 1 | One-cycle pulse after the last sample |

## Verification
Let E0 be the edge that accepts start. Sample k appears after edge E0+2+k, so valid_o is seen at the falling edges numbered 3 to 155 after E0. done_o and the drop of busy_o are due at falling edge 156. The bench counts falling edges from E0 and tests each output at the exact count the requirements give. Its memory model returns data one edge after the address. A start is injected in the middle of a pass and the bench keeps watching for 25 cycles after done. This shows that no second pass and no extra valid sample appear.

// File: rtl/boxsm_pkg.sv
package boxsm_pkg;

  // index of the highest power of two not above v
  function automatic int floor_log2(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 30; i++) begin
      if ((1 << (i + 1)) <= v) r = i + 1;
    end
    return r;
  endfunction

  // tag carried with each window step
  typedef struct packed {
    logic vld;
    logic real_s;
    logic last;
  } step_t;

endpackage

// File: rtl/boxsm_seq.sv
module boxsm_seq #(
  parameter int N_SAMP  = 136,
  parameter int PAD     = 9,
  parameter int OUT_LEN = 153,
  parameter int ADDR_W  = 8,
  parameter int POS_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                busy_i,
  output logic                accept_o,
  output boxsm_pkg::step_t    step_o,
  output logic                rd_en_o,
  output logic [ADDR_W-1:0]   rd_addr_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(OUT_LEN - 1);
  localparam logic [POS_W-1:0] DATA_LO  = POS_W'(PAD);
  localparam logic [POS_W-1:0] DATA_HI  = POS_W'(PAD + N_SAMP);

  logic             run_q;
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] off;
  logic             in_data;
  logic             at_end;

  assign accept_o = start_i & ~busy_i;
  assign at_end   = (pos_q == LAST_POS);
  assign in_data  = run_q && (pos_q >= DATA_LO) && (pos_q < DATA_HI);
  assign off      = pos_q - DATA_LO;

  // padding positions issue no read
  assign rd_en_o   = in_data;
  assign rd_addr_o = in_data ? off[ADDR_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pos_q <= '0;
    end else if (accept_o) begin
      run_q <= 1'b1;
      pos_q <= '0;
    end else if (run_q) begin
      pos_q <= pos_q + 1'b1;
      if (at_end) run_q <= 1'b0;
    end
  end

  assign step_o.vld    = run_q;
  assign step_o.real_s = in_data;
  assign step_o.last   = run_q & at_end;

endmodule

// File: rtl/boxsm_tap_line.sv
module boxsm_tap_line #(
  parameter int DEPTH = 19,
  parameter int W     = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] tail_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    logic [W-1:0] q;
    logic [W-1:0] nxt;
    if (g == 0) begin : g_head
      assign nxt = din_i;
    end else begin : g_body
      assign nxt = g_tap[g-1].q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (clr_i)   q <= '0;
      else if (shift_i) q <= nxt;
    end
  end

  // sample that drops out of the window on the next shift
  assign tail_o = g_tap[DEPTH-1].q;

endmodule

// File: rtl/boxsm_win_acc.sv
module boxsm_win_acc #(
  parameter int SAMP_W = 15,
  parameter int ACC_W  = 20,
  parameter int SHIFT  = 4,
  parameter int OUT_W  = 15
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  boxsm_pkg::step_t    step_i,
  input  logic [SAMP_W-1:0]   rd_data_i,
  input  logic [SAMP_W-1:0]   tail_i,
  output logic                shift_o,
  output logic [SAMP_W-1:0]   sample_o,
  output logic                valid_o,
  output logic [OUT_W-1:0]    smooth_o,
  output logic                done_o
);
  localparam logic [ACC_W-1:0] OUT_MAX = ACC_W'((64'd1 << OUT_W) - 64'd1);

  boxsm_pkg::step_t s1_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;
  logic [ACC_W-1:0] scaled;
  logic [OUT_W-1:0] clipped;
  logic             last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_q <= '0;
    else         s1_q <= step_i;
  end

  assign sample_o = s1_q.real_s ? rd_data_i : '0;
  assign shift_o  = s1_q.vld;
  assign acc_nxt  = acc_q + ACC_W'(sample_o) - ACC_W'(tail_i);
  assign scaled   = acc_nxt >> SHIFT;
  assign clipped  = (scaled > OUT_MAX) ? OUT_MAX[OUT_W-1:0] : scaled[OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        acc_q <= '0;
    else if (clr_i)     acc_q <= '0;
    else if (s1_q.vld)  acc_q <= acc_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      last_q   <= 1'b0;
      smooth_o <= '0;
      done_o   <= 1'b0;
    end else begin
      valid_o <= s1_q.vld;
      last_q  <= s1_q.vld & s1_q.last;
      done_o  <= valid_o & last_q;
      if (s1_q.vld) smooth_o <= clipped;
    end
  end

endmodule

// File: rtl/boxcar_smoother.sv
module boxcar_smoother #(
  parameter int N_SAMP  = 136,
  parameter int SAMP_W  = 15,
  parameter int WIN_DIV = 7,
  parameter int OUT_W   = 15
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  output logic                        rd_en_o,
  output logic [$clog2(N_SAMP)-1:0]   rd_addr_o,
  input  logic [SAMP_W-1:0]           rd_data_i,
  output logic                        busy_o,
  output logic                        valid_o,
  output logic [OUT_W-1:0]            smooth_o,
  output logic                        done_o
);
  localparam int WIN     = N_SAMP / WIN_DIV;
  localparam int PAD     = WIN / 2;
  localparam int OUT_LEN = N_SAMP + 2 * PAD - 1;
  localparam int SHIFT   = boxsm_pkg::floor_log2(WIN);
  localparam int ACC_W   = SAMP_W + $clog2(WIN + 1);
  localparam int ADDR_W  = $clog2(N_SAMP);
  localparam int POS_W   = $clog2(OUT_LEN + 1);

  boxsm_pkg::step_t step;
  logic             accept;
  logic             shift;
  logic [SAMP_W-1:0] sample;
  logic [SAMP_W-1:0] tail;

  assign busy_o = step.vld | shift | valid_o;

  boxsm_seq #(
    .N_SAMP (N_SAMP),
    .PAD    (PAD),
    .OUT_LEN(OUT_LEN),
    .ADDR_W (ADDR_W),
    .POS_W  (POS_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_i   (busy_o),
    .accept_o (accept),
    .step_o   (step),
    .rd_en_o  (rd_en_o),
    .rd_addr_o(rd_addr_o)
  );

  boxsm_tap_line #(
    .DEPTH(WIN),
    .W    (SAMP_W)
  ) u_taps (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .shift_i(shift),
    .din_i  (sample),
    .tail_o (tail)
  );

  boxsm_win_acc #(
    .SAMP_W(SAMP_W),
    .ACC_W (ACC_W),
    .SHIFT (SHIFT),
    .OUT_W (OUT_W)
  ) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .step_i   (step),
    .rd_data_i(rd_data_i),
    .tail_i   (tail),
    .shift_o  (shift),
    .sample_o (sample),
    .valid_o  (valid_o),
    .smooth_o (smooth_o),
    .done_o   (done_o)
  );

endmodule

// File: rtl/boxsm_chk.sv
module boxsm_chk #(
  parameter int N_SAMP  = 136,
  parameter int ADDR_W  = 8,
  parameter int OUT_LEN = 153
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              rd_en_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              busy_o,
  input logic              valid_o,
  input logic              done_o
);
  logic [15:0] vcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vcnt <= '0;
    else if (done_o)  vcnt <= '0;
    else if (valid_o) vcnt <= vcnt + 16'd1;
  end

  // R3
  sample_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> vcnt == 16'(OUT_LEN));

  // R3
  valid_unbroken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> done_o);

  // R8
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!valid_o && $past(valid_o)));

  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> rd_addr_o < ADDR_W'(N_SAMP));

  // R6
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o)) |-> rd_addr_o == $past(rd_addr_o) + 1'b1);

  // R7
  busy_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(busy_o));

  // R9
  ignore_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && start_i) |=> (valid_o || done_o));

endmodule

bind boxcar_smoother boxsm_chk #(
  .N_SAMP (N_SAMP),
  .ADDR_W (ADDR_W),
  .OUT_LEN(OUT_LEN)
) u_boxsm_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .rd_en_o  (rd_en_o),
  .rd_addr_o(rd_addr_o),
  .busy_o   (busy_o),
  .valid_o  (valid_o),
  .done_o   (done_o)
);

// File: tb/boxcar_smoother_bench.sv
module boxcar_smoother_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 136;
  localparam int OLEN = 153;
  localparam int WINL = 19;
  localparam int PADL = 9;
  localparam int NPAT = 6;
  // kind (0 const, 1 ramp, 2 dip, 3 pseudo-random), parameter, inject start mid-pass
  localparam int PATS [NPAT][3] = '{
    '{0, 16,    0},
    '{1, 241,   0},
    '{2, 900,   1},
    '{3, 12345, 0},
    '{0, 32767, 0},
    '{2, 0,     1}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        rd_en_o;
  logic [7:0]  rd_addr_o;
  logic [14:0] rd_data_i = '0;
  logic        busy_o;
  logic        valid_o;
  logic [14:0] smooth_o;
  logic        done_o;

  logic [14:0] mem [N];
  int cap [OLEN];
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i) if (rd_en_o) rd_data_i <= mem[rd_addr_o];

  boxcar_smoother u_boxcar_smoother (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .valid_o(valid_o), .smooth_o(smooth_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  function automatic int model(input int k);
    int s;
    s = 0;
    for (int p = (k >= WINL - 1 ? k - WINL + 1 : 0); p <= k; p++)
      if (p >= PADL && p < PADL + N) s += int'(mem[p - PADL]);
    s = s >> 4;
    return (s > 32767) ? 32767 : s;
  endfunction

  task automatic fill(input int kind, input int prm);
    int unsigned x;
    x = prm;
    for (int i = 0; i < N; i++) begin
      case (kind)
        0: mem[i] = 15'(prm);
        1: mem[i] = 15'(i * prm);
        2: mem[i] = (i >= 50 && i < 86) ? 15'(prm) : 15'd30000;
        default: begin
          x = x * 1103515245 + 12345;
          mem[i] = 15'(x >> 9);
        end
      endcase
    end
  endtask

  task automatic run_pass(input bit inject, input string tag);
    int vcount, first_n, done_cnt, done_n, rcount, busy_bad, bad_vals, bad_k;
    bit rd_bad;
    vcount = 0; first_n = -1; done_cnt = 0; done_n = -1; rcount = 0;
    busy_bad = 0; bad_vals = 0; bad_k = -1; rd_bad = 0;
    start_i = 1'b1;
    for (int n = 1; n <= 180; n++) begin
      @(negedge clk_i);
      if (valid_o) begin
        if (vcount < OLEN) cap[vcount] = int'(smooth_o);
        if (vcount == 0) first_n = n;
        vcount++;
      end
      if (done_o) begin done_cnt++; done_n = n; end
      if (rd_en_o) begin
        if (int'(rd_addr_o) != rcount) rd_bad = 1;
        rcount++;
      end
      if (busy_o != (n <= 155)) busy_bad++;
      if (n == 1) start_i = 1'b0;
      if (inject && n == 50) start_i = 1'b1;
      if (inject && n == 51) start_i = 1'b0;
    end
    chk(first_n == 3, {"R2 first sample latency ", tag}, first_n, 3);
    chk(vcount == OLEN, {"R3 sample count ", tag}, vcount, OLEN);
    for (int k = 0; k < OLEN; k++)
      if (cap[k] != model(k) && bad_k < 0) begin bad_k = k; bad_vals++; end
    chk(bad_k < 0, {"R4 R5 R10 smoothed values ", tag},
        bad_k < 0 ? 0 : cap[bad_k], bad_k < 0 ? 0 : model(bad_k));
    chk(rcount == N && !rd_bad, {"R6 reads ", tag}, rcount, N);
    chk(busy_bad == 0, {"R7 busy window ", tag}, busy_bad, 0);
    chk(done_cnt == 1 && done_n == 156, {"R8 done pulse ", tag}, done_n, 156);
    if (inject) chk(vcount == OLEN && done_cnt == 1, {"R9 mid-pass start ignored ", tag}, vcount, OLEN);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !valid_o && !done_o && !rd_en_o, "R1 reset state",
        {busy_o, valid_o, done_o, rd_en_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !valid_o && !done_o && !rd_en_o, "R1 idle after release",
        {busy_o, valid_o, done_o, rd_en_o}, 0);

    for (int t = 0; t < NPAT; t++) begin
      fill(PATS[t][0], PATS[t][1]);
      run_pass(PATS[t][2] != 0, $sformatf("pattern %0d", t));
    end

    // R4 hand values for three window phases, constant 16
    fill(0, 16);
    run_pass(1'b0, "const16");
    chk(cap[8] == 0,    "R4 window all padding", cap[8], 0);
    chk(cap[9] == 1,    "R4 entry phase first sample", cap[9], 1);
    chk(cap[27] == 19,  "R4 full overlap", cap[27], 19);
    chk(cap[152] == 11, "R4 exit phase last sample", cap[152], 11);

    // R5 saturation at full scale
    fill(0, 32767);
    run_pass(1'b0, "fullscale");
    chk(cap[27] == 32767, "R5 saturated mid sample", cap[27], 32767);
    chk(cap[9] == 2047,   "R5 unsaturated entry sample", cap[9], 2047);

    report();
    $finish;
  end

endmodule